// File: doc/BRIEF.md
# Prioritized Locality Ownership Arbiter

Five host localities share one security-module host interface, and only one of them owns it at a time. Each locality reaches the block through its own 4 KB window: address bits [14:12] give the locality number, and the access byte sits at offset 0 of that window. A host claims ownership, gives it up, queues a request or takes it by force by writing to its access byte. Reading the byte shows that locality's own view of the arbitration.

The arbiter reports the owning locality and a valid flag. It emits a one-cycle locality-changed event, tagged with the new owner, for the interrupt logic. When `cmd_busy` shows that a command is running, a handover is not carried out at once. The block raises `abort_req`, keeps the target in a next-owner register, and completes the switch when `abort_done` pulses.

Control is a three-state machine:
- `ST_FREE`: no owner.
- `ST_HELD`: a locality owns the interface.
- `ST_ABORTING`: a handover waits for the abort to finish.

Transitions:
- claim: FREE to HELD.
- release: HELD to FREE, when nobody is waiting.
- handover: HELD to HELD, applied at once.
- defer: HELD to ABORTING.
- retarget: ABORTING to ABORTING, when a higher seize is accepted.
- complete: ABORTING to HELD, on `abort_done`.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface, no event is pending, and every access byte reads 0x80 with bit 0 taken from `est_bit`.
- R2: Access byte layout on read:
  - bit 7: always 1.
  - bit 5: the reader is the owner.
  - bit 4: been-seized.
  - bit 3: always reads 0.
  - bit 2: set when any other locality holds request-use.
  - bit 1: request-use.
  - bit 0: `est_bit`.
- R3: A write with bit 1 set, made while no locality owns the interface, makes the writer the owner at once.
- R4: A write with bit 1 set from a non-owner, made while another locality owns the interface, only latches request-use for the writer. The owner is unchanged.
- R5: An owner write with bit 5 set releases ownership.
  - The highest-numbered locality with request-use becomes the owner, and its request-use is cleared.
  - If no locality holds request-use, no locality owns the interface.
- R6: A write with bit 5 set from a non-owner clears that locality's own request-use.
- R7: A write with bit 3 set (seize) is accepted under three conditions:
  - no locality owns the interface, or the writer's number is higher than the owner's;
  - the writer has no seize pending;
  - no higher locality has a seize pending.

  Accepting a seize clears the pending seizes of all lower localities.
- R8: A seize write ignores bits 1 and 5 of the same byte. Writing bit 4 as 1 clears been-seized.
- R9: After a seize handover the old owner reads been-seized set. After a normal handover the old owner's been-seized is unchanged.
- R10: Each change of owner to a valid locality pulses `loc_chg` for one cycle, with `loc_chg_idx` equal to the new owner. A release to no owner gives no pulse.
- R11: Writes to locality 4, and writes to any offset other than 0, have no effect on the arbitration.
- R12: When a handover away from an owner is requested while `cmd_busy` is 1:
  - `abort_req` pulses for one cycle;
  - the owner is kept until `abort_done`;
  - the switch then completes on the `abort_done` edge.
- R13: While a handover waits for `abort_done`:
  - owner releases are ignored;
  - request-use writes still latch;
  - a seize accepted under R7 retargets the pending handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 15 | Byte address; [14:12] is the locality |
| acc_wr | input | 1 | Write strobe, one byte |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Access byte of the addressed locality (combinational) |
| est_bit | input | 1 | Value shown in bit 0 of every access byte |
| cmd_busy | input | 1 | A command is executing |
| abort_done | input | 1 | Pulse: the requested abort has finished |
| abort_req | output | 1 | Pulse: abort the running command |
| owner_vld | output | 1 | Some locality owns the interface |
| owner_idx | output | 3 | Owning locality |
| loc_chg | output | 1 | Locality-changed event pulse |
| loc_chg_idx | output | 3 | New owner carried with the event |

## Verification
A write is taken on the clock edge where `acc_wr` is high. Owner, flags, `abort_req` and `loc_chg` all change on that same edge, so `acc_rdata` reflects the write from the next cycle on. A deferred handover completes on the edge that samples `abort_done`. The bench drives every input at the falling edge and reads `acc_rdata` and the owner outputs one falling edge after the write. Event and abort pulses are counted by a rising-edge monitor, and each write task idles one more cycle before the counts are compared.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    typedef enum logic [1:0] {
        ST_FREE     = 2'd0,
        ST_HELD     = 2'd1,
        ST_ABORTING = 2'd2
    } arb_state_e;

    // access byte bit positions (host software decodes these)
    localparam int B_VALID = 7;
    localparam int B_ACT   = 5;
    localparam int B_BS    = 4;
    localparam int B_SZ    = 3;
    localparam int B_PEND  = 2;
    localparam int B_REQ   = 1;
    localparam int B_EST   = 0;

endpackage

// File: rtl/loc_arb_pick.sv
// Picks the highest-numbered set bit of a request vector.
module loc_arb_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/loc_arb_view.sv
// Builds the access byte seen by each locality and selects the addressed one.
module loc_arb_view
    import loc_arb_pkg::*;
#(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_q,
    input  logic [N-1:0]  bs_q,
    input  logic          owner_vld,
    input  logic [IW-1:0] owner_idx,
    input  logic [IW-1:0] rloc,
    input  logic          est_bit,
    output logic [7:0]    rdata
);
    logic [7:0] view [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_view
            logic [N-1:0] others;
            always_comb begin
                others    = req_q;
                others[g] = 1'b0;
                view[g]          = 8'h00;
                view[g][B_VALID] = 1'b1;
                view[g][B_ACT]   = owner_vld && (owner_idx == IW'(g));
                view[g][B_BS]    = bs_q[g];
                view[g][B_SZ]    = 1'b0;
                view[g][B_PEND]  = |others;
                view[g][B_REQ]   = req_q[g];
                view[g][B_EST]   = est_bit;
            end
        end
    endgenerate

    always_comb begin
        rdata = 8'hFF;
        for (int i = 0; i < N; i++) begin
            if (rloc == IW'(i)) rdata = view[i];
        end
    end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC   = 5,
    parameter int LOC_SHIFT = 12,
    parameter int LOC_W     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LOC_SHIFT+LOC_W-1:0] acc_addr,
    input  logic                       acc_wr,
    input  logic [7:0]                 acc_wdata,
    output logic [7:0]                 acc_rdata,
    input  logic                       est_bit,
    input  logic                       cmd_busy,
    input  logic                       abort_done,
    output logic                       abort_req,
    output logic                       owner_vld,
    output logic [LOC_W-1:0]           owner_idx,
    output logic                       loc_chg,
    output logic [LOC_W-1:0]           loc_chg_idx
);
    localparam int ADDR_W = LOC_SHIFT + LOC_W;
    localparam logic [LOC_W-1:0] HW_LOC = LOC_W'(NUM_LOC - 1);

    arb_state_e st_q, st_d;
    logic [NUM_LOC-1:0] req_q, req_d, sz_q, sz_d, bs_q, bs_d;
    logic               vld_q, vld_d;
    logic [LOC_W-1:0]   own_q, own_d;
    logic [LOC_W-1:0]   nxt_q, nxt_d;
    logic               nxt_sz_q, nxt_sz_d;
    logic               chg_d, abreq_d;
    logic [LOC_W-1:0]   chg_idx_d;

    // ---------------- address decode ----------------
    logic [LOC_W-1:0] wl;
    logic             wr_hit;
    assign wl     = acc_addr[ADDR_W-1:LOC_SHIFT];
    assign wr_hit = acc_wr && (acc_addr[LOC_SHIFT-1:0] == '0) && (wl < HW_LOC);

    // ---------------- helpers ----------------
    logic             hi_hit;
    logic [LOC_W-1:0] hi_idx;
    loc_arb_pick #(.N(NUM_LOC), .IW(LOC_W)) u_pick (
        .req (req_q),
        .hit (hi_hit),
        .idx (hi_idx)
    );

    loc_arb_view #(.N(NUM_LOC), .IW(LOC_W)) u_view (
        .req_q     (req_q),
        .bs_q      (bs_q),
        .owner_vld (vld_q),
        .owner_idx (own_q),
        .rloc      (wl),
        .est_bit   (est_bit),
        .rdata     (acc_rdata)
    );

    logic higher_sz;
    always_comb begin
        higher_sz = 1'b0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (LOC_W'(i) > wl && sz_q[i]) higher_sz = 1'b1;
        end
    end

    // ---------------- write interpretation ----------------
    logic [7:0]       v;
    logic             go;        // ownership move requested by this write
    logic             go_sz;     // move comes from a seize
    logic [LOC_W-1:0] go_tgt;
    logic             rel_none;  // owner release with nobody waiting
    logic             wr_eff;
    logic [NUM_LOC-1:0] req_w, sz_w, bs_w;

    always_comb begin
        v        = acc_wdata;
        if (v[B_SZ]) begin
            v[B_REQ] = 1'b0;
            v[B_ACT] = 1'b0;
        end
        wr_eff   = wr_hit && !(st_q == ST_ABORTING && abort_done);
        go       = 1'b0;
        go_sz    = 1'b0;
        go_tgt   = '0;
        rel_none = 1'b0;
        req_w    = req_q;
        sz_w     = sz_q;
        bs_w     = bs_q;
        if (wr_eff) begin
            if (v[B_ACT]) begin
                if (vld_q && own_q == wl) begin
                    if (st_q != ST_ABORTING) begin
                        if (hi_hit) begin
                            go     = 1'b1;
                            go_tgt = hi_idx;
                        end else begin
                            rel_none = 1'b1;
                        end
                    end
                end else begin
                    req_w[wl] = 1'b0;
                end
            end
            if (v[B_BS]) bs_w[wl] = 1'b0;
            if (v[B_SZ]) begin
                if ((!vld_q || wl > own_q) && !sz_q[wl] && !higher_sz) begin
                    for (int i = 0; i < NUM_LOC; i++) begin
                        if (LOC_W'(i) < wl) sz_w[i] = 1'b0;
                    end
                    sz_w[wl] = 1'b1;
                    go       = 1'b1;
                    go_sz    = 1'b1;
                    go_tgt   = wl;
                end
            end
            if (v[B_REQ]) begin
                if (vld_q && own_q != wl) begin
                    req_w[wl] = 1'b1;
                end else if (!vld_q) begin
                    go     = 1'b1;
                    go_tgt = wl;
                end
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        req_d     = req_w;
        sz_d      = sz_w;
        bs_d      = bs_w;
        vld_d     = vld_q;
        own_d     = own_q;
        nxt_d     = nxt_q;
        nxt_sz_d  = nxt_sz_q;
        chg_d     = 1'b0;
        chg_idx_d = loc_chg_idx;
        abreq_d   = 1'b0;
        unique case (st_q)
            ST_FREE: begin
                if (go) begin                       // claim
                    req_d[go_tgt] = 1'b0;
                    sz_d[go_tgt]  = 1'b0;
                    vld_d         = 1'b1;
                    own_d         = go_tgt;
                    chg_d         = 1'b1;
                    chg_idx_d     = go_tgt;
                    st_d          = ST_HELD;
                end
            end
            ST_HELD: begin
                if (go && cmd_busy) begin           // defer
                    nxt_d    = go_tgt;
                    nxt_sz_d = go_sz;
                    abreq_d  = 1'b1;
                    st_d     = ST_ABORTING;
                end else if (go) begin              // handover
                    if (go_sz) bs_d[own_q] = 1'b1;
                    else       req_d[own_q] = 1'b0;
                    req_d[go_tgt] = 1'b0;
                    sz_d[go_tgt]  = 1'b0;
                    own_d         = go_tgt;
                    chg_d         = 1'b1;
                    chg_idx_d     = go_tgt;
                end else if (rel_none) begin        // release
                    vld_d = 1'b0;
                    st_d  = ST_FREE;
                end
            end
            ST_ABORTING: begin
                if (abort_done) begin               // complete
                    if (nxt_sz_q) bs_d[own_q] = 1'b1;
                    else          req_d[own_q] = 1'b0;
                    req_d[nxt_q] = 1'b0;
                    sz_d[nxt_q]  = 1'b0;
                    own_d        = nxt_q;
                    chg_d        = 1'b1;
                    chg_idx_d    = nxt_q;
                    st_d         = ST_HELD;
                end else if (go) begin              // retarget
                    nxt_d    = go_tgt;
                    nxt_sz_d = go_sz;
                end
            end
            default: st_d = ST_FREE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_FREE;
            req_q       <= '0;
            sz_q        <= '0;
            bs_q        <= '0;
            vld_q       <= 1'b0;
            own_q       <= '0;
            nxt_q       <= '0;
            nxt_sz_q    <= 1'b0;
            loc_chg     <= 1'b0;
            loc_chg_idx <= '0;
            abort_req   <= 1'b0;
        end else begin
            st_q        <= st_d;
            req_q       <= req_d;
            sz_q        <= sz_d;
            bs_q        <= bs_d;
            vld_q       <= vld_d;
            own_q       <= own_d;
            nxt_q       <= nxt_d;
            nxt_sz_q    <= nxt_sz_d;
            loc_chg     <= chg_d;
            loc_chg_idx <= chg_idx_d;
            abort_req   <= abreq_d;
        end
    end

    // ---------------- outputs ----------------
    assign owner_vld = vld_q;
    assign owner_idx = own_q;

    // ---------------- assertions ----------------
    AST_OWNER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        owner_vld |-> (owner_idx < LOC_W'(NUM_LOC)));                      // R5
    AST_OWNER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        owner_vld |-> !((req_q >> owner_idx) & NUM_LOC'(1)));              // R5
    AST_CHG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        loc_chg |-> (owner_vld && owner_idx == loc_chg_idx));              // R10
    AST_SWITCH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld && $past(owner_vld) && owner_idx != $past(owner_idx)) |-> loc_chg); // R10
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ABORTING && $past(st_q) == ST_ABORTING) |-> ($stable(owner_idx) && owner_vld)); // R12
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);                                          // R12
    AST_TOP_LOC_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && wl == HW_LOC && st_q != ST_ABORTING) |=> ($stable(owner_vld) && $stable(owner_idx))); // R11

endmodule

// File: tb/loc_arbiter_test.sv
module loc_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] acc_addr;
    logic        acc_wr;
    logic [7:0]  acc_wdata;
    logic [7:0]  acc_rdata;
    logic        est_bit;
    logic        cmd_busy;
    logic        abort_done;
    logic        abort_req;
    logic        owner_vld;
    logic [2:0]  owner_idx;
    logic        loc_chg;
    logic [2:0]  loc_chg_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int chg_cnt = 0;
    int ab_cnt  = 0;
    int chg_last = -1;

    always #10 clk = ~clk;   // 50 MHz

    loc_arbiter uut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .est_bit(est_bit),
        .cmd_busy(cmd_busy), .abort_done(abort_done), .abort_req(abort_req),
        .owner_vld(owner_vld), .owner_idx(owner_idx), .loc_chg(loc_chg),
        .loc_chg_idx(loc_chg_idx)
    );

    always @(posedge clk) begin
        if (rst_n && loc_chg) begin
            chg_cnt  <= chg_cnt + 1;
            chg_last <= int'(loc_chg_idx);
        end
        if (rst_n && abort_req) ab_cnt <= ab_cnt + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
        cmd_busy = 1'b0; abort_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chg_cnt = 0; ab_cnt = 0; chg_last = -1;
    endtask

    task automatic wr_at(input int loc, input int off, input int data);
        @(negedge clk);
        acc_addr  = 15'((loc << 12) | off);
        acc_wdata = 8'(data);
        acc_wr    = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input int loc, input int data);
        wr_at(loc, 0, data);
    endtask

    task automatic rd(input int loc, output int val);
        acc_addr = 15'(loc << 12);
        #2;
        val = int'(acc_rdata);
    endtask

    task automatic chk_rd(input string tag, input int loc, input int exp);
        int val;
        rd(loc, val);
        check(tag, val, exp);
    endtask

    task automatic chk_owner(input string tag, input int exp);   // -1 = none
        check(tag, owner_vld ? int'(owner_idx) : -1, exp);
    endtask

    task automatic pulse_abort_done();
        @(negedge clk);
        abort_done = 1'b1;
        @(negedge clk);
        abort_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c0, e;
        est_bit = 1'b0;
        do_reset();

        // R1 reset state
        chk_owner("R1 owner after reset", -1);
        check("R1 no event", int'(loc_chg), 0);
        for (int l = 0; l < 5; l++) chk_rd("R1 access byte", l, 8'h80);
        est_bit = 1'b1;
        chk_rd("R2 est bit", 2, 8'h81);
        est_bit = 1'b0;

        // R3 claim from free, each writable locality
        for (int a = 0; a < 4; a++) begin
            do_reset();
            wr(a, 8'h02);
            chk_owner("R3 claim owner", a);
            check("R10 claim event count", chg_cnt, 1);
            check("R10 claim event idx", chg_last, a);
            for (int l = 0; l < 5; l++)
                chk_rd("R2 view after claim", l, (l == a) ? 8'hA0 : 8'h80);
        end

        // R4 / R2 pending / R6 over all owner-requester pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (b == a) continue;
                do_reset();
                wr(a, 8'h02);
                wr(b, 8'h02);
                chk_owner("R4 owner kept", a);
                chk_rd("R2 owner sees pending", a, 8'hA4);
                chk_rd("R4 requester latched", b, 8'h82);
                for (int l = 0; l < 5; l++)
                    if (l != a && l != b) chk_rd("R2 others pending", l, 8'h84);
                wr(b, 8'h20);
                chk_rd("R6 request withdrawn", b, 8'h80);
                chk_rd("R6 owner no pending", a, 8'hA0);
                chk_owner("R6 owner kept", a);
            end
        end

        // R5 release order, R9 normal handover, R10 no event on release to none
        do_reset();
        wr(0, 8'h02); wr(1, 8'h02); wr(3, 8'h02); wr(2, 8'h02);
        wr(0, 8'h20);
        chk_owner("R5 highest requester", 3);
        check("R10 event idx 3", chg_last, 3);
        chk_rd("R9 normal handover no been-seized", 0, 8'h84);
        chk_rd("R5 new owner req cleared", 3, 8'hA4);
        wr(3, 8'h20);
        chk_owner("R5 next requester", 2);
        wr(2, 8'h20);
        chk_owner("R5 last requester", 1);
        c0 = chg_cnt;
        wr(1, 8'h20);
        chk_owner("R5 release to none", -1);
        check("R10 no event on release to none", chg_cnt, c0);
        chk_rd("R5 old owner after release", 1, 8'h80);

        // R7 seize acceptance sweep, R9 been-seized, R8 clear
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (b == a) continue;
                do_reset();
                wr(a, 8'h02);
                wr(b, 8'h08);
                e = (b > a) ? b : a;
                chk_owner("R7 seize outcome", e);
                check("R10 seize event count", chg_cnt, (b > a) ? 2 : 1);
                if (b > a) begin
                    chk_rd("R9 old owner been-seized", a, 8'h90);
                    chk_rd("R7 seizer owns", b, 8'hA0);
                    wr(a, 8'h10);
                    chk_rd("R8 been-seized cleared", a, 8'h80);
                end else begin
                    chk_rd("R2 seize bit hidden", b, 8'h80);
                end
            end
        end
        do_reset();
        wr(2, 8'h08);
        chk_owner("R7 seize when free", 2);

        // R8 masking of request and active bits in a seize write
        do_reset();
        wr(0, 8'h02);
        wr(2, 8'h0A);
        chk_rd("R8 no request latched", 2, 8'hA0);
        chk_rd("R8 old owner", 0, 8'h90);
        wr(1, 8'h2A);
        chk_owner("R8 refused seize keeps owner", 2);
        chk_rd("R8 refused seize no request", 1, 8'h80);

        // R11 locality 4 and other offsets ignored
        do_reset();
        wr(4, 8'h02);
        chk_owner("R11 loc4 claim ignored", -1);
        wr(1, 8'h02);
        wr(4, 8'h08);
        chk_owner("R11 loc4 seize ignored", 1);
        chk_rd("R11 loc4 readable", 4, 8'h80);
        wr_at(2, 4, 8'h02);
        chk_rd("R11 other offset ignored", 2, 8'h80);
        chk_owner("R11 owner kept", 1);

        // R12 deferred release
        do_reset();
        wr(0, 8'h02);
        wr(2, 8'h02);
        cmd_busy = 1'b1;
        c0 = chg_cnt;
        wr(0, 8'h20);
        chk_owner("R12 owner held during abort", 0);
        check("R12 abort request pulse", ab_cnt, 1);
        check("R12 no event yet", chg_cnt, c0);
        chk_rd("R12 owner view", 0, 8'hA4);
        pulse_abort_done();
        chk_owner("R12 switch after abort", 2);
        check("R12 event on completion", chg_last, 2);
        check("R12 single abort pulse", ab_cnt, 1);
        cmd_busy = 1'b0;

        // R13 writes while waiting
        do_reset();
        wr(0, 8'h02);
        cmd_busy = 1'b1;
        wr(3, 8'h08);
        chk_owner("R13 seize deferred", 0);
        wr(1, 8'h02);
        chk_rd("R13 request latches", 1, 8'h82);
        wr(0, 8'h20);
        chk_owner("R13 release ignored", 0);
        wr(2, 8'h08);
        chk_owner("R13 lower seize ignored", 0);
        pulse_abort_done();
        chk_owner("R13 seizer owns", 3);
        chk_rd("R9 deferred seize been-seized", 0, 8'h94);
        chk_rd("R13 new owner view", 3, 8'hA4);

        // R13 retarget by higher seize
        do_reset();
        wr(0, 8'h02);
        cmd_busy = 1'b1;
        wr(1, 8'h08);
        wr(3, 8'h08);
        pulse_abort_done();
        chk_owner("R13 retarget to higher seize", 3);
        check("R10 retarget event idx", chg_last, 3);
        cmd_busy = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule